// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block holds the two threshold offsets used by a FIFO's flag logic. The lower one, here called the almost-empty offset, sets how close to empty the FIFO may get before the warning flag fires. The upper one, the almost-full offset, does the same near full. When reset is released, two select inputs choose one of four ways to fill both offsets:
- a fixed value of 8;
- a fixed value of 64;
- two words captured from the write port;
- a serial bit stream clocked in on a separate data/enable pair.

The block also drives an input-ready qualifier. While the offsets are still being loaded it keeps the FIFO write path closed, so no word reaches memory until both values are settled. All logic runs on the write-port clock. Reset is synchronous and active low. The memory array and the flag comparators sit outside this block and read `ofs_ae` and `ofs_af`.

Top module: `fifo_ofs_loader`

## Requirements
- R1: The mode is taken from `{sel_hi, sel_lo}` as sampled at the last clock edge with `rst_n` low: 2'b11 serial load, 2'b10 preset 64, 2'b01 preset 8, 2'b00 parallel load. Select changes after release have no effect until the next reset.
- R2: While `rst_n` is low, and until loading completes, `in_ready`, `config_done` and `mem_wr` are low, whatever `wr_en` does.
- R3: In either preset mode, both offsets equal the preset value. `in_ready` and `config_done` are low after the first clock edge following release and high after the second.
- R4: In parallel mode, `in_ready` goes high after the second clock edge following release. `config_done` stays low until two qualified writes have been taken.
- R5: In parallel mode, the first qualified write (`wr_en` high while `in_ready` is high) loads `ofs_af` from `wr_data[8:0]`, with bit 8 as the MSB. The second qualified write loads `ofs_ae`. Neither write raises `mem_wr`.
- R6: A write strobe seen while `in_ready` is low is ignored. It loads no offset and does not count toward the two loading writes.
- R7: In serial mode, each clock edge with `ser_en_n` low shifts one bit of `ser_data` in, and edges with `ser_en_n` high take nothing. After 18 bits, `ofs_af[8]` holds the first bit and `ofs_ae[0]` holds the last bit.
- R8: In serial mode, `in_ready` stays low through the edge that takes the 18th bit and goes high on the next clock edge.
- R9: Serial bits offered after the 18th are ignored until the next reset, and both offsets keep their values.
- R10: Once `config_done` is high, `mem_wr` follows `wr_en`, and further writes leave both offsets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-port clock |
| rst_n | input | 1 | Synchronous active-low reset; mode selects are sampled while it is low |
| sel_hi | input | 1 | Mode select, upper bit |
| sel_lo | input | 1 | Mode select, lower bit |
| wr_en | input | 1 | Write strobe from the write port |
| wr_data | input | 9 | Write data; bits 8..0 carry an offset during parallel load |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_data | input | 1 | Serial offset bit |
| ofs_ae | output | 9 | Almost-empty offset |
| ofs_af | output | 9 | Almost-full offset |
| in_ready | output | 1 | Write port may accept writes |
| config_done | output | 1 | Offsets final; writes now go to memory |
| mem_wr | output | 1 | Write strobe forwarded to FIFO memory |

## Verification
The hardest case to reach is the boundary of the serial stream. The bench must show that `in_ready` is still low after the 18th bit and rises one edge later. It must also show that bits offered past the 18th change nothing. To get there, the stimulus streams a known pair of offsets with a one-cycle enable gap in the middle, which proves that gated edges take no bit. It then holds the enable low for several more cycles while toggling the data line. The parallel case is built the same way: the strobe is held high across the two startup edges, so any premature capture would shift which word lands in which offset.

// File: rtl/ofs_load_pkg.sv
package ofs_load_pkg;

   typedef enum logic [1:0] {
      MODE_PARALLEL = 2'b00,
      MODE_PRE_LO   = 2'b01,
      MODE_PRE_HI   = 2'b10,
      MODE_SERIAL   = 2'b11
   } ofs_mode_e;

endpackage

// File: rtl/ofs_start_timer.sv
// Counts clock edges after reset release and flags when the startup wait is over.
module ofs_start_timer #(
   parameter int EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   generate
      if (EDGES == 0) begin : g_none
         assign done = rst_n;
      end else begin : g_count
         localparam int CW = $clog2(EDGES + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q != CW'(EDGES))
               cnt_q <= cnt_q + 1'b1;
         end

         assign done = (cnt_q == CW'(EDGES));
      end
   endgenerate
endmodule

// File: rtl/ofs_serial_shift.sv
// Shifts the concatenated {af, ae} offsets in MSB first. Bits beyond the total are dropped.
module ofs_serial_shift #(
   parameter int W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enable,
   input  logic           ser_en_n,
   input  logic           ser_data,
   output logic [2*W-1:0] shreg,
   output logic           ready
);
   localparam int TOTAL = 2 * W;
   localparam int CW    = $clog2(TOTAL + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt_q <= '0;
         ready <= 1'b0;
      end else begin
         if (enable && !ser_en_n && (cnt_q != CW'(TOTAL))) begin
            shreg <= {shreg[TOTAL-2:0], ser_data};
            cnt_q <= cnt_q + 1'b1;
         end
         ready <= (cnt_q == CW'(TOTAL));
      end
   end
endmodule

// File: rtl/ofs_parallel_cap.sv
// Takes the first two qualified writes as the almost-full and then the almost-empty offset.
module ofs_parallel_cap #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         wr_qual,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] af_q,
   output logic [W-1:0] ae_q,
   output logic         done
);
   logic [1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         af_q  <= '0;
         ae_q  <= '0;
         cnt_q <= '0;
      end else if (enable && wr_qual && (cnt_q != 2'd2)) begin
         if (cnt_q == 2'd0)
            af_q <= wr_data;
         else
            ae_q <= wr_data;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == 2'd2);
endmodule

// File: rtl/fifo_ofs_loader.sv
module fifo_ofs_loader
   import ofs_load_pkg::*;
#(
   parameter int OFS_W         = 9,
   parameter int DATA_W        = 9,
   parameter int PRESET_LO     = 8,
   parameter int PRESET_HI     = 64,
   parameter int STARTUP_EDGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_hi,
   input  logic              sel_lo,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ser_en_n,
   input  logic              ser_data,
   output logic [OFS_W-1:0]  ofs_ae,
   output logic [OFS_W-1:0]  ofs_af,
   output logic              in_ready,
   output logic              config_done,
   output logic              mem_wr
);
   localparam int OFS_MAX = (1 << OFS_W) - 4;

   generate
      if (DATA_W < OFS_W) begin : g_bad_dw
         $error("DATA_W must be at least OFS_W");
      end
      if (PRESET_LO < 1 || PRESET_LO > OFS_MAX) begin : g_bad_lo
         $error("PRESET_LO outside legal offset range");
      end
      if (PRESET_HI < 1 || PRESET_HI > OFS_MAX) begin : g_bad_hi
         $error("PRESET_HI outside legal offset range");
      end
   endgenerate

   ofs_mode_e mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= ofs_mode_e'({sel_hi, sel_lo});
   end

   logic start_done;
   ofs_start_timer #(.EDGES(STARTUP_EDGES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (start_done)
   );

   logic [2*OFS_W-1:0] ser_word;
   logic               ser_rdy;
   ofs_serial_shift #(.W(OFS_W)) u_serial (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (mode_q == MODE_SERIAL),
      .ser_en_n (ser_en_n),
      .ser_data (ser_data),
      .shreg    (ser_word),
      .ready    (ser_rdy)
   );

   logic             wr_qual;
   logic [OFS_W-1:0] par_af, par_ae;
   logic             par_done;
   ofs_parallel_cap #(.W(OFS_W)) u_par (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (mode_q == MODE_PARALLEL),
      .wr_qual (wr_qual),
      .wr_data (wr_data[OFS_W-1:0]),
      .af_q    (par_af),
      .ae_q    (par_ae),
      .done    (par_done)
   );

   assign in_ready    = rst_n && start_done && ((mode_q != MODE_SERIAL) || ser_rdy);
   assign wr_qual     = wr_en && in_ready;
   assign config_done = in_ready && ((mode_q != MODE_PARALLEL) || par_done);
   assign mem_wr      = wr_en && config_done;

   always_comb begin
      unique case (mode_q)
         MODE_PRE_LO: begin
            ofs_af = OFS_W'(PRESET_LO);
            ofs_ae = OFS_W'(PRESET_LO);
         end
         MODE_PRE_HI: begin
            ofs_af = OFS_W'(PRESET_HI);
            ofs_ae = OFS_W'(PRESET_HI);
         end
         MODE_SERIAL: begin
            ofs_af = ser_word[2*OFS_W-1:OFS_W];
            ofs_ae = ser_word[OFS_W-1:0];
         end
         default: begin
            ofs_af = par_af;
            ofs_ae = par_ae;
         end
      endcase
   end
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
   parameter int OFS_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [OFS_W-1:0] ofs_ae,
   input logic [OFS_W-1:0] ofs_af,
   input logic             in_ready,
   input logic             config_done,
   input logic             mem_wr
);
   // R2: nothing is open on the first cycle after release
   a_r2_closed_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!in_ready && !config_done));

   // R8: once raised, in_ready stays high until the next reset
   a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_ready) |-> in_ready);

   // R4: loading can only finish with the port ready
   a_r4_done_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      config_done |-> in_ready);

   // R5: no memory write while offsets are still being loaded
   a_r5_no_memwr_loading: assert property (@(posedge clk) disable iff (!rst_n)
      !config_done |-> !mem_wr);

   // R9 / R10: offsets are frozen after loading completes
   a_r10_offsets_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(config_done) && config_done) |-> ($stable(ofs_ae) && $stable(ofs_af)));

   // R10: a memory write always comes from a write strobe
   a_r10_memwr_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> wr_en);
endmodule

bind fifo_ofs_loader ofs_loader_chk #(.OFS_W(OFS_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .ofs_ae      (ofs_ae),
   .ofs_af      (ofs_af),
   .in_ready    (in_ready),
   .config_done (config_done),
   .mem_wr      (mem_wr)
);

// File: tb/fifo_ofs_loader_tb_top.sv
module fifo_ofs_loader_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_hi = 1'b0, sel_lo = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       ser_en_n = 1'b1, ser_data = 1'b0;
   logic [8:0] ofs_ae, ofs_af;
   logic       in_ready, config_done, mem_wr;

   int n_vec  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   fifo_ofs_loader dut_i (
      .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(sel_lo),
      .wr_en(wr_en), .wr_data(wr_data), .ser_en_n(ser_en_n), .ser_data(ser_data),
      .ofs_ae(ofs_ae), .ofs_af(ofs_af), .in_ready(in_ready),
      .config_done(config_done), .mem_wr(mem_wr)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   // Reset with one select value for the early edges and another at the last edge.
   task automatic do_reset(input logic [1:0] early, input logic [1:0] last);
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b1; ser_en_n = 1'b1; wr_data = 9'd77;
      {sel_hi, sel_lo} = early;
      repeat (2) @(negedge clk);
      chk("R2 ready low in reset", in_ready, 0);
      chk("R2 done low in reset", config_done, 0);
      chk("R2 mem_wr low in reset", mem_wr, 0);
      {sel_hi, sel_lo} = last;
      @(negedge clk);
      rst_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic t_preset_lo();
      do_reset(2'b11, 2'b01);
      {sel_hi, sel_lo} = 2'b11;           // R1: noise after release
      @(negedge clk);
      chk("R3 ready low after edge 1", in_ready, 0);
      chk("R3 done low after edge 1", config_done, 0);
      @(negedge clk);
      chk("R3 ready high after edge 2", in_ready, 1);
      chk("R3 done high after edge 2", config_done, 1);
      chk("R1 R3 ae preset 8", ofs_ae, 8);
      chk("R1 R3 af preset 8", ofs_af, 8);
      wr_en = 1'b1;
      #1 chk("R10 mem_wr follows wr_en", mem_wr, 1);
      wr_en = 1'b0;
      #1 chk("R10 mem_wr drops with wr_en", mem_wr, 0);
   endtask

   task automatic t_preset_hi();
      do_reset(2'b00, 2'b10);
      {sel_hi, sel_lo} = 2'b01;
      repeat (2) @(negedge clk);
      chk("R1 R3 ae preset 64", ofs_ae, 64);
      chk("R1 R3 af preset 64", ofs_af, 64);
      chk("R3 ready preset 64", in_ready, 1);
   endtask

   task automatic t_parallel();
      do_reset(2'b10, 2'b00);
      wr_en = 1'b1; wr_data = 9'd99;     // R6: strobe across the startup edges
      @(negedge clk);
      chk("R4 ready low after edge 1", in_ready, 0);
      @(negedge clk);
      chk("R4 ready high after edge 2", in_ready, 1);
      chk("R6 early writes not counted", config_done, 0);
      chk("R5 no mem_wr on load write", mem_wr, 0);
      wr_data = 9'd200;
      @(negedge clk);
      chk("R5 af from first write", ofs_af, 200);
      chk("R4 done low after one write", config_done, 0);
      chk("R5 no mem_wr on second load write", mem_wr, 0);
      wr_data = 9'd17;
      @(negedge clk);
      chk("R5 ae from second write", ofs_ae, 17);
      chk("R5 af kept", ofs_af, 200);
      chk("R4 done after two writes", config_done, 1);
      chk("R10 mem_wr passes after load", mem_wr, 1);
      wr_data = 9'd333;
      @(negedge clk);
      chk("R10 ae unchanged by data write", ofs_ae, 17);
      chk("R10 af unchanged by data write", ofs_af, 200);
      wr_en = 1'b0;
   endtask

   task automatic t_serial();
      logic [17:0] word;
      word = {9'd300, 9'd5};
      do_reset(2'b00, 2'b11);
      wr_en = 1'b1; wr_data = 9'd1;
      for (int i = 0; i < 18; i++) begin
         if (i == 9) begin                  // R7: gated edge takes nothing
            ser_en_n = 1'b1; ser_data = ~word[17-i];
            @(negedge clk);
         end
         ser_en_n = 1'b0; ser_data = word[17-i];
         @(negedge clk);
         if (i == 16) chk("R8 ready low after 17 bits", in_ready, 0);
      end
      chk("R8 ready low right after 18th bit", in_ready, 0);
      chk("R2 no mem_wr during serial load", mem_wr, 0);
      ser_data = 1'b1;                      // R9: extra bits start here
      @(negedge clk);
      chk("R8 ready high edge after last bit", in_ready, 1);
      chk("R7 af from serial stream", ofs_af, 300);
      chk("R7 ae from serial stream", ofs_ae, 5);
      chk("R10 mem_wr after serial load", mem_wr, 1);
      for (int i = 0; i < 4; i++) begin
         ser_data = i[0];
         @(negedge clk);
      end
      chk("R9 af ignores extra bits", ofs_af, 300);
      chk("R9 ae ignores extra bits", ofs_ae, 5);
      ser_en_n = 1'b1; wr_en = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      t_preset_lo();
      t_preset_hi();
      t_parallel();
      t_serial();
      t_parallel();
      finish_run();
   end
endmodule